// File: doc/BRIEF.md
# Clock Source Crosspoint with Register Control

This block routes clock sources to clock outputs under register control. Seven source signals arrive on one input bus, all in the same clock domain as the register port. The sources are the reference, three taps of a first divider bank and three taps of a second divider bank. Each of six outputs picks one source with a 3-bit select code and is gated by its own enable bit. An output that is disabled, or that selects the reserved code, is held low.

Software programs the block through a byte-wide port made of an address, write data, a write strobe and a read data bus. The six select codes are packed into a 24-bit image that spans three consecutive byte registers. Two codes straddle byte boundaries, and two 3-bit groups of the image are fixed filler that always read back as ones. A fourth register holds the enables. A write to any other address changes nothing.

Top module: `clkx_xbar`

## Requirements
- R1: After reset every enable is 0, every select code is 000 and every output is low. Reads return 0x00 at 0x09, 0x00 at 0x44, 0x0E at 0x45 and 0x07 at 0x46.
- R2: An enabled output whose code is c (0 to 6) follows src_in bit c. The bits are: 0 reference, 1 bank-1 programmable divide, 2 bank-1 /2, 3 bank-1 /3, 4 bank-2 programmable divide, 5 bank-2 /2, 6 bank-2 /4.
- R3: An output whose code is 111 is driven low whatever the sources are.
- R4: Register 0x09 bit k (k = 0..5) enables output k+1, where 1 means enabled. Bits 7..6 always read 0.
- R5: Register 0x44 holds output 1's code in bits 7..5, output 2's code in bits 4..2, and bits 2..1 of output 3's code in bits 1..0.
- R6: Register 0x45 holds bit 0 of output 3's code in bit 7, output 4's code in bits 6..4, and bit 2 of output 5's code in bit 0. Bits 3..1 read 111 whatever value was written.
- R7: Register 0x46 holds bits 1..0 of output 5's code in bits 7..6 and output 6's code in bits 5..3. Bits 2..0 read 111 whatever value was written.
- R8: A write to any address other than 0x09 and 0x44 to 0x46 changes no state. A read of such an address returns 0x00.
- R9: A write takes effect at the rising clock edge on which reg_we is high. reg_rdata is a combinational function of reg_addr and the stored state.
- R10: An output whose enable bit is 0 is driven low whatever its code and the sources are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_rdata | output | 8 | Read data for reg_addr |
| src_in | input | 7 | Source signals, bit index equals select code |
| clk_out | output | 6 | Routed and gated outputs, bit k is output k+1 |

## Verification
The routing is exercised in eight rounds. In each round output k carries code (round+k) mod 8, so every output sees every code, including 111, and neighbouring outputs never share a code. Every round is repeated under three enable masks, and each configuration is driven with all 128 source patterns. Because every source bit is toggled on its own, a route to the wrong source shows up, and so does a wrong gate or a field landing on the wrong output. Every configuration is written with its filler bits cleared and then read back, which separates correct packing and filler forcing from field slips across byte boundaries. A sweep over all 256 addresses, writing ones everywhere outside the map, shows whether any decode aliases onto live state.

// File: rtl/clkx_pkg.sv
package clkx_pkg;

  localparam int SEL_W   = 3;
  localparam int N_OUT   = 6;
  localparam int N_SRC   = 7;
  localparam int BYTE_W  = 8;
  localparam int N_LANE  = 3;
  localparam int IMG_W   = N_LANE * BYTE_W;
  localparam int FILL_W  = 3;

  typedef logic [SEL_W-1:0]            sel_t;
  typedef logic [N_OUT-1:0][SEL_W-1:0] sel_vec_t;
  typedef logic [IMG_W-1:0]            img_t;

  // Filler groups sit in image bits 11..9 and 2..0.
  localparam img_t FILL_MASK = img_t'(24'h000E07);

  localparam sel_t SEL_RSVD = sel_t'('1);

  // Low bit of output idx's field in the image. A filler group follows the
  // fourth field, so later fields shift down by one extra group.
  function automatic int field_lsb(input int idx);
    int base;
    base = IMG_W - SEL_W * (idx + 1);
    if (idx >= 4) base = base - FILL_W;
    return base;
  endfunction

  function automatic img_t pack_image(input sel_vec_t codes);
    img_t img;
    img = FILL_MASK;
    for (int i = 0; i < N_OUT; i++) begin
      img[field_lsb(i) +: SEL_W] = codes[i];
    end
    return img;
  endfunction

  function automatic sel_vec_t unpack_image(input img_t img);
    sel_vec_t codes;
    for (int i = 0; i < N_OUT; i++) begin
      codes[i] = img[field_lsb(i) +: SEL_W];
    end
    return codes;
  endfunction

  function automatic logic [BYTE_W-1:0] lane_of(input img_t img, input int lane);
    return img[(N_LANE - 1 - lane) * BYTE_W +: BYTE_W];
  endfunction

  function automatic logic code_usable(input sel_t code);
    return (code != SEL_RSVD);
  endfunction

endpackage

// File: rtl/clkx_regs.sv
module clkx_regs
  import clkx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = BYTE_W,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h09,
  parameter logic [ADDR_W-1:0] SEL_BASE = 8'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output sel_vec_t          sel_vec,
  output logic [N_OUT-1:0]  en_vec
);

  sel_vec_t           sel_q;
  sel_vec_t           sel_d;
  logic [N_OUT-1:0]   en_q;
  img_t               img_cur;
  img_t               img_wr;
  logic [N_LANE-1:0]  lane_sel;
  logic [N_LANE-1:0]  lane_wr;
  logic               en_sel;
  logic               wr_en;
  logic               wr_sel_any;
  logic               wr_ignored;

  genvar k;
  generate
    for (k = 0; k < N_LANE; k++) begin : g_lane
      assign lane_sel[k] = (addr == ADDR_W'(SEL_BASE + k));
      assign lane_wr[k]  = we && lane_sel[k];
    end
  endgenerate

  assign en_sel     = (addr == EN_ADDR);
  assign wr_en      = we && en_sel;
  assign wr_sel_any = |lane_wr;
  assign wr_ignored = we && !en_sel && !(|lane_sel);

  assign img_cur = pack_image(sel_q);

  always_comb begin
    img_wr = img_cur;
    for (int j = 0; j < N_LANE; j++) begin
      if (lane_wr[j]) img_wr[(N_LANE - 1 - j) * DATA_W +: DATA_W] = wdata;
    end
    sel_d = unpack_image(img_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_sel_any) sel_q <= sel_d;
      if (wr_en)      en_q  <= wdata[N_OUT-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int j = 0; j < N_LANE; j++) begin
      if (lane_sel[j]) rdata = lane_of(img_cur, j);
    end
    if (en_sel) rdata = DATA_W'(en_q);
  end

  assign sel_vec = sel_q;
  assign en_vec  = en_q;

  // R8
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> ($stable(sel_q) && $stable(en_q)));

  // R9
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(wdata[N_OUT-1:0])));

  // R4
  en_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_sel |-> (rdata[DATA_W-1:N_OUT] == '0));

  // R6
  fill_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_sel[1] |-> (rdata[3:1] == 3'b111));

  // R7
  fill_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_sel[2] |-> (rdata[2:0] == 3'b111));

endmodule

// File: rtl/clkx_route.sv
module clkx_route
  import clkx_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src,
  input  sel_t          sel,
  input  logic          en,
  output logic          out
);

  logic picked;
  logic pass;

  always_comb begin
    picked = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (sel == SEL_W'(s)) picked = src[s];
    end
  end

  assign pass = en && code_usable(sel);
  assign out  = pass && picked;

  // R3
  code_reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_RSVD) |-> !out);

  // R10
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !out);

  // R2
  src_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> !out);

endmodule

// File: rtl/clkx_xbar.sv
module clkx_xbar
  import clkx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0]  src_in,
  output logic [N_OUT-1:0]  clk_out
);

  sel_vec_t         sel_vec;
  logic [N_OUT-1:0] en_vec;

  clkx_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .we      (reg_we),
    .rdata   (reg_rdata),
    .sel_vec (sel_vec),
    .en_vec  (en_vec)
  );

  genvar i;
  generate
    for (i = 0; i < N_OUT; i++) begin : g_out
      clkx_route #(.NS(N_SRC)) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_in),
        .sel   (sel_vec[i]),
        .en    (en_vec[i]),
        .out   (clk_out[i])
      );
    end
  endgenerate

  // R1
  reset_out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> (clk_out == '0));

endmodule

// File: tb/clkx_xbar_tb.sv
`timescale 1ns/1ps
module clkx_xbar_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic [6:0] src_in = '0;
  logic [5:0] clk_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [2:0] cfg [6];
  logic [5:0] en_m;

  always #2.5 clk = ~clk;

  clkx_xbar u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .src_in    (src_in),
    .clk_out   (clk_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected register bytes, built field by field from the requirements.
  function automatic logic [7:0] exp44();
    return {cfg[0], cfg[1], cfg[2][2], cfg[2][1]};
  endfunction
  function automatic logic [7:0] exp45();
    return {cfg[2][0], cfg[3], 3'b111, cfg[4][2]};
  endfunction
  function automatic logic [7:0] exp46();
    return {cfg[4][1], cfg[4][0], cfg[5], 3'b111};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  function automatic logic exp_out(input int k, input logic [6:0] s);
    if (!en_m[k]) return 1'b0;
    if (cfg[k] == 3'd7) return 1'b0;
    return s[cfg[k]];
  endfunction

  // Writes fillers as 0; reads must still show them as 1.
  task automatic program_cfg();
    wr(8'h44, exp44());
    wr(8'h45, exp45() & 8'hF1);
    wr(8'h46, exp46() & 8'hF8);
    wr(8'h09, {2'b11, en_m});
    rd_chk(8'h44, exp44(), "R5");
    rd_chk(8'h45, exp45(), "R6");
    rd_chk(8'h46, exp46(), "R7");
    rd_chk(8'h09, {2'b00, en_m}, "R4");
  endtask

  task automatic sweep_src();
    for (int p = 0; p < 128; p++) begin
      src_in = 7'(p);
      #1;
      for (int k = 0; k < 6; k++) begin
        logic e;
        e = exp_out(k, 7'(p));
        if (!en_m[k])            check(clk_out[k] == e, "R10", clk_out[k], e);
        else if (cfg[k] == 3'd7) check(clk_out[k] == e, "R3", clk_out[k], e);
        else                     check(clk_out[k] == e, "R2", clk_out[k], e);
      end
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [5:0] masks [3];
    masks[0] = 6'h3F; masks[1] = 6'h15; masks[2] = 6'h2A;

    // R1: reset state
    src_in = 7'h7F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(clk_out == 6'h00, "R1", clk_out, 0);
    rd_chk(8'h09, 8'h00, "R1");
    rd_chk(8'h44, 8'h00, "R1");
    rd_chk(8'h45, 8'h0E, "R1");
    rd_chk(8'h46, 8'h07, "R1");

    // R9: write lands on the clock edge, not before
    @(negedge clk);
    reg_addr = 8'h09; reg_wdata = 8'h3F; reg_we = 1'b1;
    #1;
    check(reg_rdata == 8'h00, "R9", reg_rdata, 8'h00);
    @(posedge clk); #1;
    reg_we = 1'b0;
    check(reg_rdata == 8'h3F, "R9", reg_rdata, 8'h3F);
    @(negedge clk);

    // Main sweep: every output sees every code under three enable masks
    for (int r = 0; r < 8; r++) begin
      for (int m = 0; m < 3; m++) begin
        for (int k = 0; k < 6; k++) cfg[k] = 3'((r + k) % 8);
        en_m = masks[m];
        program_cfg();
        sweep_src();
      end
    end

    // R8: writes everywhere outside the map are ignored and read as zero
    for (int k = 0; k < 6; k++) cfg[k] = 3'(k + 1);
    en_m = 6'h3F;
    program_cfg();
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h09 && a != 8'h44 && a != 8'h45 && a != 8'h46) begin
        wr(8'(a), 8'hFF);
        rd_chk(8'(a), 8'h00, "R8");
      end
    end
    rd_chk(8'h44, exp44(), "R8");
    rd_chk(8'h45, exp45(), "R8");
    rd_chk(8'h46, exp46(), "R8");
    rd_chk(8'h09, {2'b00, en_m}, "R8");
    sweep_src();

    // R10: disabling all outputs forces them low
    en_m = 6'h00;
    wr(8'h09, 8'h00);
    src_in = 7'h7F;
    #1;
    check(clk_out == 6'h00, "R10", clk_out, 0);

    summary();
  end

endmodule